// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A walk begins when the requester presents a virtual address and a table base value with a start strobe. The walker then fetches one or two descriptor words over a simple request/response memory port. It reports the physical address and the two cacheable/bufferable attribute bits, or a fault, with a one-cycle completion pulse.

A first-level descriptor maps a 1 MB section directly, or points at one of two kinds of second-level table. A coarse table holds 256 entries and a fine table holds 1024. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page. A configuration input decides whether fine tables are accepted. Only one walk is in flight at a time.

The controller is a six-state machine. IDLE waits for a start. L1_REQ holds the first-level read request until the memory accepts it. L1_WAIT waits for the first-level word and decodes it. From L1_WAIT the walk goes to L2_REQ when the descriptor points at a table, and to FIN on a section, a fault or a memory error. L2_REQ holds the second-level read request. L2_WAIT waits for that word and always goes to FIN. FIN raises the completion pulse and returns to IDLE.

Top module: `xlat_walker`

## Requirements
- R1: The first read goes to the address {base[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with bits 1:0 = 00 completes the walk with a fault after a single read.
- R3: A first-level descriptor with bits 1:0 = 11 completes the walk with a fault after a single read when fine_tbl_en was low at the accepted start. fine_tbl_en is sampled at the start.
- R4: A first-level descriptor with bits 1:0 = 10 is a section. The result is {desc[31:20], va[19:0]}, with no fault and no second read.
- R5: The attribute output attr_cb equals bits 3:2 of the descriptor that ends a successful walk.
- R6: A first-level descriptor with bits 1:0 = 01 makes the second read go to {desc[31:10], va[19:12], 2'b00}.
- R7: A first-level descriptor with bits 1:0 = 11, with fine tables enabled, makes the second read go to {desc[31:12], va[19:10], 2'b00}.
- R8: A second-level descriptor selects the result by its bits 1:0. 01 gives {d[31:16], va[15:0]}. 10 gives {d[31:12], va[11:0]}. 11 gives {d[31:10], va[9:0]}. 00 gives a fault.
- R9: A read request stays valid with a stable address until mem_req_ready is seen. A response with mem_rsp_err set ends the walk with a fault.
- R10: busy is high from the accepted start through the single-cycle done pulse. A start seen while busy is ignored and produces no further request or done pulse.
- R11: A synchronous reset returns the walker to idle, with busy, done, fault and mem_req_valid all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start a walk, taken only when idle |
| start_va | input | 32 | Virtual address to translate |
| start_base | input | 32 | Table base value; bits 31:14 are used |
| fine_tbl_en | input | 1 | Accept fine second-level tables, sampled at start |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The walk failed; valid with done |
| phys_addr | output | 32 | Translated address; valid with done |
| attr_cb | output | 2 | Cacheable/bufferable bits; valid with done |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | The read failed |

## Verification
The bench targets the two table-index widths, because a coarse or fine walk that used the other's slice of the virtual address would read the wrong second-level word. It covers all three page sizes, since a wrong offset mask splices the wrong bits into the result. It also checks that a fine descriptor faults after a single read when fine tables are disabled, and that a first-level fault issues no second read. Further tests hold the memory ready low to confirm the request and address do not move, and inject a response error that must become a fault. Finally, the bench sends start requests during a walk, which must not restart it, and resets the walker mid-walk, which must drop every output.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CBW = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_FIN
    } walk_state_e;

    // encodings of descriptor bits 1:0
    typedef enum logic [1:0] {
        L1_INVALID = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_INVALID = 2'b00,
        L2_LARGE   = 2'b01,
        L2_SMALL   = 2'b10,
        L2_TINY    = 2'b11
    } l2_kind_e;
endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
    import xlat_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] va,
    input  logic          fine_ok,
    output logic          is_fault,
    output logic          is_leaf,
    output logic [AW-1:0] leaf_pa,
    output logic [AW-1:0] next_addr
);
    l1_kind_e kind;

    always_comb begin
        kind      = l1_kind_e'(desc[1:0]);
        is_fault  = 1'b0;
        is_leaf   = 1'b0;
        leaf_pa   = {desc[31:20], va[19:0]};
        next_addr = '0;
        unique case (kind)
            L1_INVALID: is_fault = 1'b1;
            L1_SECTION: is_leaf  = 1'b1;
            L1_COARSE:  next_addr = {desc[31:10], va[19:12], 2'b00};
            L1_FINE: begin
                is_fault  = !fine_ok;
                next_addr = {desc[31:12], va[19:10], 2'b00};
            end
        endcase
    end
endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
    import xlat_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] va,
    output logic          is_fault,
    output logic [AW-1:0] page_pa
);
    l2_kind_e kind;

    always_comb begin
        kind     = l2_kind_e'(desc[1:0]);
        is_fault = 1'b0;
        page_pa  = '0;
        unique case (kind)
            L2_INVALID: is_fault = 1'b1;
            L2_LARGE:   page_pa = {desc[31:16], va[15:0]};
            L2_SMALL:   page_pa = {desc[31:12], va[11:0]};
            L2_TINY:    page_pa = {desc[31:10], va[9:0]};
        endcase
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start_valid,
    input  logic [AW-1:0]  start_va,
    input  logic [AW-1:0]  start_base,
    input  logic           fine_tbl_en,
    output logic           busy,
    output logic           done,
    output logic           fault,
    output logic [AW-1:0]  phys_addr,
    output logic [CBW-1:0] attr_cb,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rsp_data,
    input  logic           mem_rsp_err
);
    walk_state_e state, state_nxt;

    logic [AW-1:0]  va_q, base_q, l2_addr_q, pa_q;
    logic           fine_q, fault_q;
    logic [CBW-1:0] cb_q;

    logic          l1_fault, l1_leaf;
    logic [AW-1:0] l1_pa, l1_next;
    logic          l2_fault;
    logic [AW-1:0] l2_pa;
    logic [AW-1:0] l1_addr;

    assign l1_addr = {base_q[31:14], va_q[31:20], 2'b00};

    xlat_l1_dec u_l1 (
        .desc      (mem_rsp_data),
        .va        (va_q),
        .fine_ok   (fine_q),
        .is_fault  (l1_fault),
        .is_leaf   (l1_leaf),
        .leaf_pa   (l1_pa),
        .next_addr (l1_next)
    );

    xlat_l2_dec u_l2 (
        .desc     (mem_rsp_data),
        .va       (va_q),
        .is_fault (l2_fault),
        .page_pa  (l2_pa)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (start_valid)   state_nxt = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_nxt = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) begin
                if (mem_rsp_err || l1_fault || l1_leaf) state_nxt = ST_FIN;
                else                                    state_nxt = ST_L2_REQ;
            end
            ST_L2_REQ:  if (mem_req_ready) state_nxt = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_nxt = ST_FIN;
            ST_FIN:     state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= '0;
            base_q    <= '0;
            fine_q    <= 1'b0;
            l2_addr_q <= '0;
            pa_q      <= '0;
            cb_q      <= '0;
            fault_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_valid) begin
                    va_q    <= start_va;
                    base_q  <= start_base;
                    fine_q  <= fine_tbl_en;
                    fault_q <= 1'b0;
                end
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || l1_fault) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                        cb_q    <= '0;
                    end else if (l1_leaf) begin
                        pa_q <= l1_pa;
                        cb_q <= mem_rsp_data[3:2];
                    end else begin
                        l2_addr_q <= l1_next;
                    end
                end
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || l2_fault) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                        cb_q    <= '0;
                    end else begin
                        pa_q <= l2_pa;
                        cb_q <= mem_rsp_data[3:2];
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_FIN);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        mem_req_addr  = (state == ST_L2_REQ) ? l2_addr_q : l1_addr;
        fault         = fault_q;
        phys_addr     = pa_q;
        attr_cb       = cb_q;
    end

    // R9: request held with stable address while not accepted
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done only while busy
    a_r10_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10: no memory traffic when idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    // R11: reset leaves the walker idle
    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req_valid && !fault));
endmodule

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic [31:0] start_va = '0;
    logic [31:0] start_base = '0;
    logic        fine_tbl_en = 1'b0;
    logic        busy, done, fault;
    logic [31:0] phys_addr;
    logic [1:0]  attr_cb;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    always #5 clk = ~clk;

    xlat_walker dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_va(start_va),
        .start_base(start_base), .fine_tbl_en(fine_tbl_en), .busy(busy), .done(done),
        .fault(fault), .phys_addr(phys_addr), .attr_cb(attr_cb),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // memory model table
    logic [31:0] tab_addr [4];
    logic [31:0] tab_data [4];
    logic        tab_err  [4];
    logic [31:0] req_log  [4];
    int          req_cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    logic [31:0] res_pa;
    logic [1:0]  res_cb;
    logic        res_fault;
    int          done_seen;

    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= 32'h0;
            for (int i = 0; i < 4; i++)
                if (tab_addr[i] == pend_addr) begin
                    mem_rsp_data <= tab_data[i];
                    mem_rsp_err  <= tab_err[i];
                end
            pend <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            if (req_cnt < 4) req_log[req_cnt] = mem_req_addr;
            req_cnt = req_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4; i++) begin
            tab_addr[i] = 32'hFFFF_FFFF; tab_data[i] = '0; tab_err[i] = 1'b0; req_log[i] = '0;
        end
        req_cnt = 0;
    endtask

    task automatic set_mem(input int i, input logic [31:0] a, input logic [31:0] d, input logic e);
        tab_addr[i] = a; tab_data[i] = d; tab_err[i] = e;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input logic fen);
        @(negedge clk);
        start_valid = 1'b1; start_va = va; start_base = base; fine_tbl_en = fen;
        @(negedge clk);
        start_valid = 1'b0; fine_tbl_en = ~fen;
        done_seen = 0;
        for (int c = 0; c < 60 && done_seen == 0; c++) begin
            if (done) begin
                done_seen = 1;
                res_pa = phys_addr; res_cb = attr_cb; res_fault = fault;
                chk(busy, "R10 busy during done", {31'b0, busy}, 32'h1);
            end else @(negedge clk);
        end
        chk(done_seen == 1, "R10 walk completes", done_seen, 1);
        @(negedge clk);
        chk(!done && !busy, "R10 done single cycle", {30'b0, done, busy}, 32'h0);
    endtask

    localparam logic [31:0] BASE = 32'h0004_C123;

    task automatic t_reset();
        chk(!busy && !done && !fault && !mem_req_valid, "R11 reset state",
            {28'b0, busy, done, fault, mem_req_valid}, 32'h0);
    endtask

    task automatic t_section();
        clear_mem();
        set_mem(0, 32'h0004_C48C, 32'hABC0_000E, 1'b0);
        run_walk(32'h1234_5678, BASE, 1'b0);
        chk(req_log[0] == 32'h0004_C48C, "R1 l1 address", req_log[0], 32'h0004_C48C);
        chk(req_cnt == 1, "R4 single read", req_cnt, 1);
        chk(!res_fault && res_pa == 32'hABC4_5678, "R4 section pa", res_pa, 32'hABC4_5678);
        chk(res_cb == 2'd3, "R5 section cb", res_cb, 3);
    endtask

    task automatic t_coarse(input logic [31:0] d2, input logic [31:0] exp_pa, input logic [1:0] exp_cb, input string tag);
        clear_mem();
        set_mem(0, 32'h0004_C014, 32'h8000_1401, 1'b0);
        set_mem(1, 32'h8000_159C, d2, 1'b0);
        run_walk(32'h0056_7ABC, BASE, 1'b0);
        chk(req_cnt == 2 && req_log[1] == 32'h8000_159C, "R6 coarse l2 address", req_log[1], 32'h8000_159C);
        chk(!res_fault && res_pa == exp_pa, tag, res_pa, exp_pa);
        chk(res_cb == exp_cb, "R5 page cb", res_cb, exp_cb);
    endtask

    task automatic t_fine(input logic fen);
        clear_mem();
        set_mem(0, 32'h0004_C028, 32'h7000_2003, 1'b0);
        set_mem(1, 32'h7000_2BCC, 32'h5555_5C07, 1'b0);
        run_walk(32'h00AB_CDEF, BASE, fen);
        if (fen) begin
            chk(req_cnt == 2 && req_log[1] == 32'h7000_2BCC, "R7 fine l2 address", req_log[1], 32'h7000_2BCC);
            chk(!res_fault && res_pa == 32'h5555_5DEF, "R8 tiny page pa", res_pa, 32'h5555_5DEF);
            chk(res_cb == 2'd1, "R5 tiny cb", res_cb, 1);
        end else begin
            chk(res_fault, "R3 fine disabled fault", res_fault, 1);
            chk(req_cnt == 1, "R3 no second read", req_cnt, 1);
        end
    endtask

    task automatic t_l1_fault();
        clear_mem();
        set_mem(0, 32'h0004_C48C, 32'h1234_5670, 1'b0);
        run_walk(32'h1234_5678, BASE, 1'b1);
        chk(res_fault, "R2 l1 invalid fault", res_fault, 1);
        chk(req_cnt == 1, "R2 single read", req_cnt, 1);
    endtask

    task automatic t_l2_fault();
        clear_mem();
        set_mem(0, 32'h0004_C014, 32'h8000_1401, 1'b0);
        set_mem(1, 32'h8000_159C, 32'hFFFF_FFFC, 1'b0);
        run_walk(32'h0056_7ABC, BASE, 1'b0);
        chk(res_fault && req_cnt == 2, "R8 l2 invalid fault", res_fault, 1);
    endtask

    task automatic t_rsp_err();
        clear_mem();
        set_mem(0, 32'h0004_C48C, 32'hABC0_000E, 1'b1);
        run_walk(32'h1234_5678, BASE, 1'b0);
        chk(res_fault, "R9 response error fault", res_fault, 1);
    endtask

    task automatic t_stall();
        logic [31:0] a0;
        bit ok;
        clear_mem();
        set_mem(0, 32'h0004_C48C, 32'hABC0_000A, 1'b0);
        mem_req_ready = 1'b0;
        @(negedge clk);
        start_valid = 1'b1; start_va = 32'h1234_5678; start_base = BASE;
        @(negedge clk);
        start_valid = 1'b0;
        a0 = mem_req_addr;
        ok = 1'b1;
        for (int c = 0; c < 5; c++) begin
            if (!mem_req_valid || mem_req_addr != a0) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok && a0 == 32'h0004_C48C, "R9 request held while stalled", a0, 32'h0004_C48C);
        chk(req_cnt == 0, "R9 no acceptance while stalled", req_cnt, 0);
        mem_req_ready = 1'b1;
        done_seen = 0;
        for (int c = 0; c < 20 && done_seen == 0; c++) begin
            if (done) begin done_seen = 1; res_pa = phys_addr; end
            else @(negedge clk);
        end
        chk(done_seen == 1 && res_pa == 32'hABC4_5678, "R9 stalled walk result", res_pa, 32'hABC4_5678);
        @(negedge clk);
    endtask

    task automatic t_busy_start();
        int dn;
        clear_mem();
        set_mem(0, 32'h0004_C48C, 32'hABC0_0006, 1'b0);
        set_mem(1, 32'h0004_CFFC, 32'h1110_0002, 1'b0);
        @(negedge clk);
        start_valid = 1'b1; start_va = 32'h1234_5678; start_base = BASE;
        @(negedge clk);
        start_va = 32'hFFF0_0000;
        dn = 0;
        for (int c = 0; c < 12; c++) begin
            if (done) begin
                dn++;
                res_pa = phys_addr;
                start_valid = 1'b1;
            end
            @(negedge clk);
            if (c > 0 && !done) start_valid = 1'b0;
        end
        start_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(dn == 1 && res_pa == 32'hABC4_5678, "R10 start while busy ignored", res_pa, 32'hABC4_5678);
        chk(req_cnt == 1 && !busy, "R10 no extra request", req_cnt, 1);
    endtask

    task automatic t_mid_reset();
        clear_mem();
        set_mem(0, 32'h0004_C014, 32'h8000_1401, 1'b0);
        set_mem(1, 32'h8000_159C, 32'h1234_5006, 1'b0);
        mem_req_ready = 1'b0;
        @(negedge clk);
        start_valid = 1'b1; start_va = 32'h0056_7ABC; start_base = BASE;
        @(negedge clk);
        start_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !fault && !mem_req_valid, "R11 reset mid-walk",
            {28'b0, busy, done, fault, mem_req_valid}, 32'h0);
        mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req_valid && !busy, "R11 stays idle after reset", {30'b0, mem_req_valid, busy}, 32'h0);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_section();
        t_coarse(32'h1234_5006, 32'h1234_5ABC, 2'd1, "R8 small page pa");
        t_coarse(32'h4321_0009, 32'h4321_7ABC, 2'd2, "R8 large page pa");
        t_fine(1'b1);
        t_fine(1'b0);
        t_l1_fault();
        t_l2_fault();
        t_rsp_err();
        t_stall();
        t_busy_start();
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule